// File: doc/BRIEF.md
# Decade Twisted-Ring Counter with Ten-Line Decoder

This block divides a slow, externally sampled count clock by ten. A five-stage twisted-ring (Johnson) register walks through ten legal states. Ten decoded lines show the current position, one hot, and a half-cycle flag indicates whether the count sits in its lower half. The flag is high for positions 0 to 4 and low for positions 5 to 9. Its rising edge occurs at the wrap from position 9 to position 0, so it can feed the count clock of a following stage to build longer decimal chains.

The three pins (count clock, inhibit and clear) are asynchronous to the fast system clock. Each passes through a synchroniser before any decision is taken. A count event is a low-to-high change of the strobe "count clock AND NOT inhibit". As a result, a rising count clock counts while inhibit is low, and a falling inhibit counts while the count clock is high. Clear forces position 0 and overrides any count event. If the register ever holds an unused pattern, it returns to position 0 on the next count event.

Top module: `decade_ring_divider`

## Requirements
- R1: After system reset, `dec_out` equals 10'b00_0000_0001 (bit k high means position k) and `tc_out` is high.
- R2: Exactly one bit of `dec_out` is high at all times outside system reset.
- R3: A rising edge of `cnt_clk_in` while `cnt_inhibit_in` is low moves the high bit from position k to position k+1, and from position 9 back to position 0.
- R4: A falling edge of `cnt_inhibit_in` while `cnt_clk_in` is high advances the position by one.
- R5: The position does not change on any of the following:
  - a `cnt_clk_in` edge while `cnt_inhibit_in` is high;
  - a falling edge of `cnt_clk_in`;
  - a rising edge of `cnt_inhibit_in`.
- R6: While the synchronised `clear_in` is high, `dec_out` is position 0 and count events are ignored. A count event that arrives in the same cycle as clear becoming active is lost. A count event that arrives in the same cycle as clear becoming inactive is taken.
- R7: `tc_out` is high for positions 0 to 4 and low for positions 5 to 9.
- R8: A pin change that creates a count event appears on `dec_out` after exactly SYNC_DEPTH+1 rising edges of `sys_clk`, which is 3 edges by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock; all state changes on its rising edge |
| sys_rst | input | 1 | Synchronous active-high system reset |
| cnt_clk_in | input | 1 | Asynchronous count clock pin |
| cnt_inhibit_in | input | 1 | Asynchronous inhibit pin; its falling edge also counts when the count clock is high |
| clear_in | input | 1 | Asynchronous active-high clear to position 0 |
| dec_out | output | 2*STAGES (10) | One-hot decoded position |
| tc_out | output | 1 | Half-cycle flag, high for the lower half of the positions |

## Verification
A count event and an active clear can land in the same system clock cycle. The bench provokes this by changing clear and the strobe pins in the same step, in both directions. When clear rises together with a rising strobe, it expects position 0. When clear falls together with a rising strobe, it expects the count to be taken. The random phase also produces such coincidences. The bench judges each of them against a reference model that applies clear first and counts only when the new clear level is low.

// File: rtl/decade_pkg.sv
package decade_pkg;
  parameter int unsigned DEF_STAGES     = 5;
  parameter int unsigned DEF_SYNC_DEPTH = 2;

  // the three asynchronous pins, carried together through the synchroniser
  typedef struct packed {
    logic clr;
    logic inh;
    logic cclk;
  } pin_set_t;
endpackage

// File: rtl/dr_sync.sv
module dr_sync #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/dr_strobe.sv
module dr_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cnt_clk,
  input  logic inhibit,
  output logic count_evt
);
  logic strobe_now;
  logic strobe_q;

  assign strobe_now = cnt_clk & ~inhibit;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe_now;
  end

  // one event per low-to-high change of the gated strobe
  assign count_evt = strobe_now & ~strobe_q;
endmodule

// File: rtl/dr_johnson.sv
module dr_johnson #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned OUTS  = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              advance,
  output logic [STAGES-1:0] state,
  output logic [OUTS-1:0]   dec_out,
  output logic              tc_out
);
  // legal ring patterns have at most one boundary between adjacent bits
  function automatic logic jc_legal(input logic [STAGES-1:0] q);
    int unsigned edges;
    edges = 0;
    for (int i = 0; i < STAGES-1; i++) edges += (q[i] != q[i+1]) ? 1 : 0;
    return edges <= 1;
  endfunction

  function automatic logic [STAGES-1:0] jc_next(input logic [STAGES-1:0] q);
    if (jc_legal(q)) return {q[STAGES-2:0], ~q[STAGES-1]};
    return '0;
  endfunction

  logic [STAGES-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst || clear)  ring_q <= '0;
    else if (advance)  ring_q <= jc_next(ring_q);
  end

  assign state = ring_q;

  // two-input decode of adjacent ring bits
  for (genvar k = 0; k < OUTS; k++) begin : g_dec
    if (k == 0) begin : g_first
      assign dec_out[k] = ~ring_q[STAGES-1] & ~ring_q[0];
    end else if (k < STAGES) begin : g_fill
      assign dec_out[k] = ring_q[k-1] & ~ring_q[k];
    end else if (k == STAGES) begin : g_full
      assign dec_out[k] = ring_q[STAGES-1] & ring_q[0];
    end else begin : g_drain
      assign dec_out[k] = ~ring_q[k-STAGES-1] & ring_q[k-STAGES];
    end
  end

  assign tc_out = ~ring_q[STAGES-1];
endmodule

// File: rtl/decade_ring_divider.sv
module decade_ring_divider
  import decade_pkg::*;
#(
  parameter int unsigned STAGES     = DEF_STAGES,
  parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH,
  localparam int unsigned OUTS      = 2 * STAGES
) (
  input  logic            sys_clk,
  input  logic            sys_rst,
  input  logic            cnt_clk_in,
  input  logic            cnt_inhibit_in,
  input  logic            clear_in,
  output logic [OUTS-1:0] dec_out,
  output logic            tc_out
);
  localparam int unsigned PIN_W = $bits(pin_set_t);

  pin_set_t          pins_raw;
  pin_set_t          pins_sync;
  logic [PIN_W-1:0]  pins_sync_vec;
  logic              count_evt;
  logic              clear_act;
  logic [STAGES-1:0] jc_state;

  assign pins_raw = '{clr: clear_in, inh: cnt_inhibit_in, cclk: cnt_clk_in};

  dr_sync #(.DEPTH(SYNC_DEPTH), .WIDTH(PIN_W)) u_sync (
    .clk (sys_clk),
    .rst (sys_rst),
    .d   (pins_raw),
    .q   (pins_sync_vec)
  );

  assign pins_sync = pin_set_t'(pins_sync_vec);
  assign clear_act = pins_sync.clr;

  dr_strobe u_strobe (
    .clk       (sys_clk),
    .rst       (sys_rst),
    .cnt_clk   (pins_sync.cclk),
    .inhibit   (pins_sync.inh),
    .count_evt (count_evt)
  );

  dr_johnson #(.STAGES(STAGES)) u_ring (
    .clk     (sys_clk),
    .rst     (sys_rst),
    .clear   (clear_act),
    .advance (count_evt),
    .state   (jc_state),
    .dec_out (dec_out),
    .tc_out  (tc_out)
  );
endmodule

// File: rtl/decade_ring_divider_chk.sv
module decade_ring_divider_chk #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned OUTS  = 2 * STAGES
) (
  input logic              sys_clk,
  input logic              sys_rst,
  input logic              count_evt,
  input logic              clear_act,
  input logic              tc_out,
  input logic [OUTS-1:0]   dec_out,
  input logic [STAGES-1:0] jc_state
);
  localparam logic [STAGES-1:0] PAIR_MASK = {1'b0, {(STAGES-1){1'b1}}};

  // R2
  onehot_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $countones(dec_out) == 1);

  // R2
  ring_legal_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $countones((jc_state ^ {1'b0, jc_state[STAGES-1:1]}) & PAIR_MASK) <= 1);

  // R3
  advance_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (count_evt && !clear_act) |=>
      dec_out == {$past(dec_out[OUTS-2:0]), $past(dec_out[OUTS-1])});

  // R5
  hold_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (!count_evt && !clear_act) |=> $stable(dec_out));

  // R6
  clear_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    clear_act |=> dec_out == OUTS'(1));

  // R7
  tc_half_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    tc_out == (|dec_out[STAGES-1:0]));
endmodule

bind decade_ring_divider decade_ring_divider_chk #(.STAGES(STAGES)) u_chk (
  .sys_clk   (sys_clk),
  .sys_rst   (sys_rst),
  .count_evt (count_evt),
  .clear_act (clear_act),
  .tc_out    (tc_out),
  .dec_out   (dec_out),
  .jc_state  (jc_state)
);

// File: tb/decade_ring_divider_test.sv
module decade_ring_divider_test;
  localparam int PER = 20;

  logic       sys_clk = 1'b0;
  logic       sys_rst = 1'b1;
  logic       p_clk   = 1'b0;
  logic       p_inh   = 1'b0;
  logic       p_clr   = 1'b0;
  logic [9:0] dec_out;
  logic       tc_out;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 0;

  always #(PER/2) sys_clk = ~sys_clk;

  decade_ring_divider uut (
    .sys_clk        (sys_clk),
    .sys_rst        (sys_rst),
    .cnt_clk_in     (p_clk),
    .cnt_inhibit_in (p_inh),
    .clear_in       (p_clr),
    .dec_out        (dec_out),
    .tc_out         (tc_out)
  );

  function automatic logic [9:0] want_dec(int m);
    logic [9:0] v;
    v = '0;
    v[m] = 1'b1;
    return v;
  endfunction

  function automatic logic want_tc(int m);
    return (m <= 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    check(req, {22'b0, dec_out}, {22'b0, want_dec(model)});
    check("R7", {31'b0, tc_out}, {31'b0, want_tc(model)});
    check("R2", $countones(dec_out), 1);
  endtask

  // drive new pin levels, advance the model, settle, compare
  task automatic apply(logic c, logic i, logic r);
    logic old_s, new_s;
    string tag;
    @(negedge sys_clk);
    old_s = p_clk & ~p_inh;
    new_s = c & ~i;
    tag = "R5";
    if (!old_s && new_s) tag = (c && !p_clk) ? "R3" : "R4";
    p_clk = c; p_inh = i; p_clr = r;
    if (r) begin
      model = 0;
      tag = "R6";
    end else if (!old_s && new_s) begin
      model = (model + 1) % 10;
    end
    repeat (4) @(negedge sys_clk);
    check_all(tag);
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4017));
    repeat (5) @(posedge sys_clk);
    @(negedge sys_clk);
    sys_rst = 1'b0;
    // R1 reset state
    check("R1", {22'b0, dec_out}, 32'h1);
    check("R1", {31'b0, tc_out}, 32'h1);

    // R3 count through a wrap, R7 along the way
    for (int n = 0; n < 12; n++) begin
      apply(1'b1, 1'b0, 1'b0);
      apply(1'b0, 1'b0, 1'b0);
    end

    // R5 inhibit blocks the count clock, R4 inhibit fall counts
    apply(1'b0, 1'b1, 1'b0);
    apply(1'b1, 1'b1, 1'b0);
    apply(1'b1, 1'b0, 1'b0);
    apply(1'b1, 1'b1, 1'b0);
    apply(1'b0, 1'b1, 1'b0);
    apply(1'b0, 1'b0, 1'b0);

    // R6 clear holds position 0 and ignores events
    apply(1'b1, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 1'b1);
    apply(1'b1, 1'b0, 1'b1);
    apply(1'b0, 1'b0, 1'b1);
    // R6 clear release together with a strobe rise: counted
    apply(1'b1, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 1'b0);
    // R6 clear rise together with a strobe rise: lost
    apply(1'b1, 1'b0, 1'b1);
    apply(1'b0, 1'b0, 1'b0);

    // R8 latency: change lands after exactly three rising edges
    apply(1'b1, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 1'b0);
    @(negedge sys_clk);
    p_clk = 1'b1;
    repeat (2) @(negedge sys_clk);
    check("R8", {22'b0, dec_out}, {22'b0, want_dec(model)});
    model = (model + 1) % 10;
    @(negedge sys_clk);
    check("R8", {22'b0, dec_out}, {22'b0, want_dec(model)});
    apply(1'b0, 1'b0, 1'b0);

    // constrained random pins with occasional clear
    for (int n = 0; n < 600; n++) begin
      apply(1'($urandom % 2), 1'($urandom % 2), ($urandom % 8) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule